// File: doc/BRIEF.md
# Descriptor Dispatcher for a Streaming DMA Engine

This block sits between a processor bus and a streaming DMA engine. Software builds a transfer request one 32-bit word at a time in a staging area, and the request is committed only when the final control word arrives with its go flag set. Committed requests wait in a small queue. They are handed to the engine one at a time, and each request's control word travels with it unchanged.

When the engine reports that a transfer has finished, the dispatcher stores the byte count and an end code in a response queue. Software polls a fill-level register and then reads the two response words. Reading the status word of a response removes that response from the queue. A control-register reset empties both queues, drops any request that is only partly written, and shows a transient resetting flag for a fixed number of cycles.

All register access uses one word-addressed port. Read data comes back registered, one cycle after the read strobe.

Top module: `desc_dispatcher`

## Requirements
- R1: Offsets 8 to 14 stage the words read-address-low, write-address-low, length, burst/sequence, stride, read-address-high and write-address-high, in that order. A write to offset 15 with bit 31 set commits those staged words together with the written control word. A write to offset 15 with bit 31 clear commits nothing.
- R2: Committed requests reach the engine in order, one at a time. For each one, `eng_go` pulses for one cycle, and the fields are held from that cycle on. The read and write addresses are formed as {high word, low word}. The next request is issued only after `done_valid`.
- R3: The status word at offset 0 has these bits: bit 0 busy (a request is queued or executing), bit 1 request queue empty, bit 2 request queue full, bit 3 response queue empty, bit 4 response queue full, bit 6 resetting, bit 9 overflow.
- R4: A commit while the request queue is full is dropped and sets sticky bit 9. Writing offset 0 with bit 9 set clears it. Writing other bits of the low ten changes no live status bit.
- R5: Bits 15:0 of the word at offset 2 give the number of queued requests. Bits 15:0 at offset 3 give the number of stored responses. Bits 15:0 at offset 4 count the requests issued since the last reset.
- R6: `done_valid` while a request executes stores {`done_bytes`, `done_code`} as one response; while idle it is ignored. Offset 16 returns the oldest byte count without removing it. Offset 17 returns the oldest end code, zero-extended, and removes that response. Both read 0 when the queue is empty.
- R7: No request is issued while the response queue is full.
- R8: Writing offset 1 with bit 1 set empties both queues, abandons the executing request, and clears the staged words, the issue count and the overflow bit. Status bit 6 and control bit 1 then read 1 for RST_CYCLES cycles and then drop.
- R9: Request word and commit writes made while resetting is shown are ignored.
- R10: When a response is stored and one is removed in the same cycle, the read returns the old oldest entry, the new entry is kept, and the count is unchanged.
- R11: Read data appears, with `bus_rvalid` high, in the cycle after `bus_rd` is sampled. Reserved offsets 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| eng_go | output | 1 | One-cycle start pulse to the engine |
| eng_read_addr | output | 64 | Source address |
| eng_write_addr | output | 64 | Destination address |
| eng_length | output | 32 | Transfer length |
| eng_burst_seq | output | 32 | Burst and sequence word |
| eng_stride | output | 32 | Stride word |
| eng_control | output | 32 | Control word of the request |
| done_valid | input | 1 | Engine reports completion |
| done_bytes | input | 32 | Bytes moved by the finished transfer |
| done_code | input | 8 | End condition code |

## Verification
Two functions of the response queue can land in the same cycle: an engine completion stores a response while a software read of offset 17 removes one. The bench sets this up by leaving one response stored while a request is executing, then raises `done_valid` and a read of offset 17 on the same edge. It then checks that the returned code is the older entry, that the fill level stays at one, and that the byte count now visible belongs to the new completion. The overflow bit is checked in a similar way: a commit into a full queue and a status write-one-to-clear are applied to the same bit, and the bench checks that the bit sets and that only a write with bit 9 set clears it.

// File: rtl/ddisp_pkg.sv
package ddisp_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int DESC_WORDS = 8;

  localparam logic [ADDR_W-1:0] OFF_STATUS     = 5'd0;
  localparam logic [ADDR_W-1:0] OFF_CTRL       = 5'd1;
  localparam logic [ADDR_W-1:0] OFF_DFILL      = 5'd2;
  localparam logic [ADDR_W-1:0] OFF_RFILL      = 5'd3;
  localparam logic [ADDR_W-1:0] OFF_SEQ        = 5'd4;
  localparam logic [ADDR_W-1:0] OFF_RESP_BYTES = 5'd16;
  localparam logic [ADDR_W-1:0] OFF_RESP_CODE  = 5'd17;
  localparam logic [1:0]        DESC_REGION    = 2'b01;

  localparam int ST_BUSY      = 0;
  localparam int ST_DEMPTY    = 1;
  localparam int ST_DFULL     = 2;
  localparam int ST_REMPTY    = 3;
  localparam int ST_RFULL     = 4;
  localparam int ST_RESETTING = 6;
  localparam int ST_OVF       = 9;
  localparam int CTL_RESET    = 1;
  localparam int DC_GO        = 31;

  typedef struct packed {
    logic [WORD_W-1:0] control;
    logic [WORD_W-1:0] wr_hi;
    logic [WORD_W-1:0] rd_hi;
    logic [WORD_W-1:0] stride;
    logic [WORD_W-1:0] burst_seq;
    logic [WORD_W-1:0] length;
    logic [WORD_W-1:0] wr_lo;
    logic [WORD_W-1:0] rd_lo;
  } desc_t;
endpackage

// File: rtl/ddisp_fifo.sv
module ddisp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  // storage without reset so that it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // R4: callers never push into a full queue
  a_r4_push_room: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R6: callers never pop an empty queue
  a_r6_pop_data: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/ddisp_stager.sv
module ddisp_stager
  import ddisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [WORD_W-1:0] wdata,
  output logic              commit,
  output desc_t             commit_desc
);
  localparam int STAGED = DESC_WORDS - 1;

  logic [WORD_W-1:0] stage_q [STAGED];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < STAGED; i++) stage_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < STAGED; i++)
        if (idx == 3'(i)) stage_q[i] <= wdata;
    end
  end

  assign commit = wr_en && (idx == 3'(STAGED)) && wdata[DC_GO];

  always_comb begin
    commit_desc.rd_lo     = stage_q[0];
    commit_desc.wr_lo     = stage_q[1];
    commit_desc.length    = stage_q[2];
    commit_desc.burst_seq = stage_q[3];
    commit_desc.stride    = stage_q[4];
    commit_desc.rd_hi     = stage_q[5];
    commit_desc.wr_hi     = stage_q[6];
    commit_desc.control   = wdata;
  end

  // R9: nothing is committed while the block is flushing
  a_r9_no_commit_flush: assert property (@(posedge clk) disable iff (rst)
    flush |-> !commit);
endmodule

// File: rtl/ddisp_issue.sv
module ddisp_issue
  import ddisp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   flush,
  input  logic   q_empty,
  input  logic   resp_full,
  input  desc_t  head,
  input  logic   done_valid,
  output logic   pop,
  output logic   active,
  output logic   go,
  output desc_t  cur,
  output logic   resp_push,
  output logic [15:0] seq
);
  assign pop       = !active && !q_empty && !resp_full && !flush;
  assign resp_push = done_valid && active && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      go     <= 1'b0;
      seq    <= '0;
      cur    <= '0;
    end else if (flush) begin
      active <= 1'b0;
      go     <= 1'b0;
      seq    <= '0;
    end else begin
      go <= pop;
      if (pop) begin
        active <= 1'b1;
        cur    <= head;
        seq    <= seq + 16'd1;
      end else if (done_valid && active) begin
        active <= 1'b0;
      end
    end
  end

  // R2: a start pulse lasts one cycle and only accompanies an executing request
  a_r2_go_single: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);
  a_r2_go_active: assert property (@(posedge clk) disable iff (rst)
    go |-> active);
  // R2: fields stay put while a request executes
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !go && $past(active)) |-> $stable(cur));
endmodule

// File: rtl/desc_dispatcher.sv
module desc_dispatcher
  import ddisp_pkg::*;
#(
  parameter int DESC_DEPTH = 4,
  parameter int RESP_DEPTH = 4,
  parameter int RST_CYCLES = 8,
  parameter int CODE_W     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        eng_go,
  output logic [63:0] eng_read_addr,
  output logic [63:0] eng_write_addr,
  output logic [31:0] eng_length,
  output logic [31:0] eng_burst_seq,
  output logic [31:0] eng_stride,
  output logic [31:0] eng_control,
  input  logic        done_valid,
  input  logic [31:0] done_bytes,
  input  logic [CODE_W-1:0] done_code
);
  localparam int DESC_W  = $bits(desc_t);
  localparam int RESP_W  = WORD_W + CODE_W;
  localparam int DCNT_W  = $clog2(DESC_DEPTH+1);
  localparam int RCNT_W  = $clog2(RESP_DEPTH+1);
  localparam int RC_W    = $clog2(RST_CYCLES+1);

  logic              rst_req, resetting, flush;
  logic [RC_W-1:0]   rst_cnt;
  logic              desc_wr, commit, dpush, dpop, dfull, dempty;
  desc_t             staged, dhead, cur;
  logic [DCNT_W-1:0] dcount;
  logic              rpush, rpop, rfull, rempty;
  logic [RESP_W-1:0] rhead;
  logic [RCNT_W-1:0] rcount;
  logic              active;
  logic [15:0]       seq;
  logic              ovf_q;
  logic [31:0]       status_w, rd_word;

  // ---------------- reset sequencer ----------------
  assign rst_req   = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[CTL_RESET];
  assign resetting = (rst_cnt != '0);
  assign flush     = rst_req || resetting;

  always_ff @(posedge clk) begin
    if (rst)                rst_cnt <= '0;
    else if (rst_req)       rst_cnt <= RC_W'(RST_CYCLES);
    else if (resetting)     rst_cnt <= rst_cnt - RC_W'(1);
  end

  // ---------------- staging and request queue ----------------
  assign desc_wr = bus_wr && (bus_addr[4:3] == DESC_REGION) && !flush;

  ddisp_stager u_stager (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(desc_wr), .idx(bus_addr[2:0]), .wdata(bus_wdata),
    .commit(commit), .commit_desc(staged)
  );

  assign dpush = commit && !dfull;

  ddisp_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_dq (
    .clk(clk), .rst(rst), .flush(flush),
    .push(dpush), .din(staged), .pop(dpop),
    .head(dhead), .count(dcount), .full(dfull), .empty(dempty)
  );

  // ---------------- issue ----------------
  ddisp_issue u_issue (
    .clk(clk), .rst(rst), .flush(flush),
    .q_empty(dempty), .resp_full(rfull), .head(dhead),
    .done_valid(done_valid),
    .pop(dpop), .active(active), .go(eng_go), .cur(cur),
    .resp_push(rpush), .seq(seq)
  );

  assign eng_read_addr  = {cur.rd_hi, cur.rd_lo};
  assign eng_write_addr = {cur.wr_hi, cur.wr_lo};
  assign eng_length     = cur.length;
  assign eng_burst_seq  = cur.burst_seq;
  assign eng_stride     = cur.stride;
  assign eng_control    = cur.control;

  // ---------------- response queue ----------------
  assign rpop = bus_rd && (bus_addr == OFF_RESP_CODE) && !rempty;

  ddisp_fifo #(.W(RESP_W), .DEPTH(RESP_DEPTH)) u_rq (
    .clk(clk), .rst(rst), .flush(flush),
    .push(rpush), .din({done_bytes, done_code}), .pop(rpop),
    .head(rhead), .count(rcount), .full(rfull), .empty(rempty)
  );

  // ---------------- sticky overflow ----------------
  always_ff @(posedge clk) begin
    if (rst || flush)                                   ovf_q <= 1'b0;
    else if (commit && dfull)                           ovf_q <= 1'b1;
    else if (bus_wr && bus_addr == OFF_STATUS && bus_wdata[ST_OVF]) ovf_q <= 1'b0;
  end

  // ---------------- register read ----------------
  always_comb begin
    status_w               = '0;
    status_w[ST_BUSY]      = !dempty || active;
    status_w[ST_DEMPTY]    = dempty;
    status_w[ST_DFULL]     = dfull;
    status_w[ST_REMPTY]    = rempty;
    status_w[ST_RFULL]     = rfull;
    status_w[ST_RESETTING] = resetting;
    status_w[ST_OVF]       = ovf_q;
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      OFF_STATUS:     rd_word = status_w;
      OFF_CTRL:       rd_word[CTL_RESET] = resetting;
      OFF_DFILL:      rd_word[15:0] = 16'(dcount);
      OFF_RFILL:      rd_word[15:0] = 16'(rcount);
      OFF_SEQ:        rd_word[15:0] = seq;
      OFF_RESP_BYTES: rd_word = rempty ? '0 : rhead[RESP_W-1 -: WORD_W];
      OFF_RESP_CODE:  rd_word = rempty ? '0 : 32'(rhead[CODE_W-1:0]);
      default:        rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  // R11: every read strobe is answered on the next cycle
  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R8: the resetting window counts down once per cycle
  a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
    (resetting && !rst_req) |=> (rst_cnt == $past(rst_cnt) - RC_W'(1)));
  // R8: both queues stay empty while resetting
  a_r8_flushed: assert property (@(posedge clk) disable iff (rst)
    resetting |-> (dempty && rempty && !active));
  // R3: a start pulse is always reported as busy
  a_r3_busy_go: assert property (@(posedge clk) disable iff (rst)
    eng_go |-> status_w[ST_BUSY]);
  // R4: overflow only rises after a commit into a full queue
  a_r4_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(commit && dfull));
  // R7: a full response queue blocks the next start
  a_r7_no_go_full: assert property (@(posedge clk) disable iff (rst)
    rfull |=> !eng_go);
endmodule

// File: tb/desc_dispatcher_tb.sv
`timescale 1ns/1ps
module desc_dispatcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        eng_go;
  logic [63:0] eng_read_addr, eng_write_addr;
  logic [31:0] eng_length, eng_burst_seq, eng_stride, eng_control;
  logic        done_valid = 1'b0;
  logic [31:0] done_bytes = '0;
  logic [7:0]  done_code = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  desc_dispatcher u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .eng_go(eng_go), .eng_read_addr(eng_read_addr),
    .eng_write_addr(eng_write_addr), .eng_length(eng_length),
    .eng_burst_seq(eng_burst_seq), .eng_stride(eng_stride),
    .eng_control(eng_control), .done_valid(done_valid),
    .done_bytes(done_bytes), .done_code(done_code)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DONE = 2'd2;
  localparam int NV = 28;
  // {op, offset, data, expected, requirement number}
  localparam logic [74:0] VEC [NV] = '{
    {OP_RD,   5'd0,  32'h0,         32'h0000000A, 4'd3},  // R3 idle status
    {OP_RD,   5'd5,  32'h0,         32'h0,        4'd11}, // R11 reserved
    {OP_WR,   5'd8,  32'h10000000,  32'h0,        4'd1},
    {OP_WR,   5'd9,  32'h20000000,  32'h0,        4'd1},
    {OP_WR,   5'd10, 32'd64,        32'h0,        4'd1},
    {OP_WR,   5'd11, 32'h7,         32'h0,        4'd1},
    {OP_WR,   5'd12, 32'h00010001,  32'h0,        4'd1},
    {OP_WR,   5'd13, 32'h1,         32'h0,        4'd1},
    {OP_WR,   5'd14, 32'h2,         32'h0,        4'd1},
    {OP_WR,   5'd15, 32'h00003000,  32'h0,        4'd1},  // R1 no go bit
    {OP_RD,   5'd2,  32'h0,         32'h0,        4'd1},
    {OP_RD,   5'd0,  32'h0,         32'h0000000A, 4'd1},
    {OP_WR,   5'd15, 32'h80000300,  32'h0,        4'd1},  // R1 commit
    {OP_RD,   5'd0,  32'h0,         32'h00000009, 4'd3},  // R3 queued
    {OP_RD,   5'd2,  32'h0,         32'h0,        4'd5},  // R5 issued
    {OP_RD,   5'd4,  32'h0,         32'h1,        4'd5},
    {OP_RD,   5'd0,  32'h0,         32'h0000000B, 4'd3},  // R3 executing
    {OP_DONE, 5'd0,  32'h40,        32'h5A,       4'd6},
    {OP_RD,   5'd3,  32'h0,         32'h1,        4'd5},
    {OP_RD,   5'd0,  32'h0,         32'h00000002, 4'd3},
    {OP_RD,   5'd16, 32'h0,         32'h40,       4'd6},  // R6 peek
    {OP_RD,   5'd16, 32'h0,         32'h40,       4'd6},
    {OP_RD,   5'd17, 32'h0,         32'h5A,       4'd6},  // R6 pop
    {OP_RD,   5'd3,  32'h0,         32'h0,        4'd6},
    {OP_RD,   5'd17, 32'h0,         32'h0,        4'd6},  // R6 empty
    {OP_DONE, 5'd0,  32'h99,        32'h01,       4'd6},  // R6 idle done
    {OP_RD,   5'd3,  32'h0,         32'h0,        4'd6},
    {OP_RD,   5'd6,  32'h0,         32'h0,        4'd11}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic done(input logic [31:0] b, input logic [7:0] c);
    done_valid = 1'b1; done_bytes = b; done_code = c;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    chk("R11 rvalid after reset", bus_rvalid, 0);
    chk("R2 no start after reset", eng_go, 0);

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      case (v[74:73])
        OP_WR:   wr(v[72:68], v[67:36]);
        OP_DONE: done(v[67:36], v[11:4]);
        default: begin
          rd(v[72:68], d);
          chk($sformatf("R%0d vector %0d", v[3:0], i), d, v[35:4]);
        end
      endcase
    end

    // R2: fields of the first request
    chk("R2 read addr",  eng_read_addr,  64'h00000001_10000000);
    chk("R2 write addr", eng_write_addr, 64'h00000002_20000000);
    chk("R2 burst",      eng_burst_seq,  32'h7);
    chk("R2 stride",     eng_stride,     32'h00010001);
    chk("R2 control",    eng_control,    32'h80000300);

    // R2: ordering, one outstanding request
    wr(5'd10, 32'd100); wr(5'd15, 32'h80000000);
    @(negedge clk);
    chk("R2 go first", eng_go, 1);
    chk("R2 len first", eng_length, 32'd100);
    wr(5'd10, 32'd200); wr(5'd15, 32'h80000000);
    idle(2);
    chk("R2 no second go", eng_go, 0);
    rd(5'd2, d); chk("R2 second queued", d, 1);
    done(32'd100, 8'h1);
    @(negedge clk);
    chk("R2 go second", eng_go, 1);
    chk("R2 len second", eng_length, 32'd200);
    done(32'd200, 8'h2);
    rd(5'd17, d); rd(5'd17, d);

    // R4: overflow of the request queue
    for (int k = 0; k < 6; k++) wr(5'd15, 32'h80000000);
    rd(5'd0, d); chk("R4 overflow set", d, 32'h20D);
    wr(5'd0, 32'h1FF);
    rd(5'd0, d); chk("R4 other bits keep", d, 32'h20D);
    wr(5'd0, 32'h200);
    rd(5'd0, d); chk("R4 overflow cleared", d, 32'h00D);
    rd(5'd2, d); chk("R5 fill full", d, 4);

    // R8 / R9: software reset
    wr(5'd1, 32'h2);
    rd(5'd0, d); chk("R8 resetting status", d, 32'h4A);
    rd(5'd1, d); chk("R8 control readback", d, 32'h2);
    wr(5'd8, 32'hDEAD0000);
    wr(5'd15, 32'h80000000);
    idle(12);
    rd(5'd0, d); chk("R9 nothing committed", d, 32'h0A);
    rd(5'd2, d); chk("R9 fill zero", d, 0);
    rd(5'd1, d); chk("R8 control drops", d, 0);
    rd(5'd4, d); chk("R8 seq cleared", d, 0);
    wr(5'd15, 32'h80000000);
    @(negedge clk);
    chk("R8 staged cleared go", eng_go, 1);
    chk("R9 staged word ignored", eng_read_addr, 64'h0);
    done(32'h0, 8'h0);
    rd(5'd17, d);

    // R7: full response queue holds back the next start
    for (int k = 0; k < 4; k++) begin
      wr(5'd15, 32'h80000000);
      @(negedge clk);
      done(32'h100 + 32'(k), 8'h10 + 8'(k));
    end
    wr(5'd15, 32'h80000000);
    idle(3);
    chk("R7 held back", eng_go, 0);
    rd(5'd0, d); chk("R7 status full", d, 32'h11);
    rd(5'd17, d); chk("R6 oldest code", d, 32'h10);
    @(negedge clk);
    chk("R7 released", eng_go, 1);
    done(32'h55, 8'h20);

    // R10: store and remove in one cycle
    rd(5'd17, d); rd(5'd17, d); rd(5'd17, d);
    wr(5'd15, 32'h80000000);
    @(negedge clk);
    done_valid = 1'b1; done_bytes = 32'h77; done_code = 8'h33;
    bus_rd = 1'b1; bus_addr = 5'd17;
    @(negedge clk);
    d = bus_rdata;
    done_valid = 1'b0; bus_rd = 1'b0;
    chk("R10 old code returned", d, 32'h20);
    chk("R11 rvalid", bus_rvalid, 1);
    rd(5'd3, d); chk("R10 count kept", d, 1);
    rd(5'd16, d); chk("R10 new bytes", d, 32'h77);

    finish_run();
  end
endmodule